// File: doc/BRIEF.md
# PCM Codec Serial Time-Slot Port

This block is the digital serial port of a telephony PCM codec. Each 8 kHz frame (125 µs) carries one companded word in each direction. The whole block runs on a fast system clock. The bit clock and the two frame strobes arrive as synchronous inputs, and the block detects the edges of the bit clock itself.

On the transmit side the encoder hands over its finished code with a one-cycle `tx_load` strobe. The code waits in a holding buffer. At the next transmit frame strobe it is copied into a shift register and sent MSB first, one bit per rising bit-clock edge. The same strobe also pulses `enc_start`, which tells the encoder to sample and convert the current frame. A code therefore leaves the port one frame after its sample was taken.

On the receive side a receive frame strobe arms a capture of eight bits. Each bit is taken on a falling bit-clock edge. When the eighth bit is in, the word is presented on `rx_word` together with a one-cycle `decode_start` pulse for the decoder.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, `dx_en`, `dx`, `enc_start` and `decode_start` are 0, `rx_word` is 0, and the holding buffer is 0. The first transmit slot after reset therefore sends 0x00.
- R2: A `tx_load` pulse stores `tx_word` in the holding buffer. The word goes out in the first transmit slot that starts after the load. A load made while a slot is being sent does not change that slot.
- R3: A transmit slot begins at a bit-clock rising edge where `fsx` is high. On that edge `dx` shows bit 7 (the MSB) of the buffered word. Each later rising edge moves to the next lower bit, and `dx` changes only after a rising edge.
- R4: `dx_en` is high for exactly 8 bit periods from the slot's start edge and is low at all other times. While `dx_en` is low, `dx` is driven 0.
- R5: If no `tx_load` arrives between two transmit slots, the later slot repeats the same word.
- R6: An `fsx` seen while a transmit slot is in progress restarts that slot from bit 7. The slot then lasts a full 8 periods from the new start.
- R7: `enc_start` pulses for exactly one system-clock cycle at each rising edge where `fsx` is high.
- R8: A rising edge with `fsr` high arms reception. `dr` is then sampled on the next 8 falling bit-clock edges, MSB first. A value present on `dr` at the rising edge and changed before the fall is not the one captured.
- R9: `decode_start` pulses for one cycle right after the 8th capturing falling edge. `rx_word` changes only together with that pulse and holds its value until the next one. With no `fsr`, no pulse occurs.
- R10: An `fsr` seen during a capture restarts the bit count. The partial word is discarded, and only the word that follows the last `fsr` is delivered, with a single `decode_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock, synchronous to `clk` |
| fsx | input | 1 | Transmit frame strobe, sampled on a bit-clock rise |
| fsr | input | 1 | Receive frame strobe, sampled on a bit-clock rise |
| dr | input | 1 | Serial receive data |
| tx_load | input | 1 | One-cycle strobe: `tx_word` is ready from the encoder |
| tx_word | input | WORD_W | Encoded word to transmit |
| enc_start | output | 1 | One-cycle pulse: sample now and start encoding |
| dx | output | 1 | Serial transmit data |
| dx_en | output | 1 | Output enable for the `dx` driver (tri-state control) |
| decode_start | output | 1 | One-cycle pulse: `rx_word` is ready for the decoder |
| rx_word | output | WORD_W | Last fully received word |

## Verification
The bench builds the port with the default `WORD_W` of 8 and a bit period of eight system clocks. The four-clock high phase of the bit clock lets the bench change `dr` between the rising and the falling edge, which separates capture on the falling edge from capture on the rising edge. Each frame lasts twelve bit periods. That leaves room for restarted slots in both directions to run their full 8 bits, and for idle periods in which `dx_en` must stay low. The received word is looped back into `tx_load`, so the one-frame transmit latency is checked against a known table of bytes.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsx,
  input  logic              fsr,
  input  logic              dr,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              enc_start,
  output logic              dx,
  output logic              dx_en,
  output logic              decode_start,
  output logic [WORD_W-1:0] rx_word
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] IDLE = CW'(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic              bclk_q;
  logic [WORD_W-1:0] hold, tx_sh, rx_sh;
  logic [CW-1:0]     tx_cnt, rx_cnt;

  wire bclk_rise = bclk & ~bclk_q;
  wire bclk_fall = ~bclk & bclk_q;
  wire tx_busy   = tx_cnt != IDLE;

  assign dx_en = tx_busy;
  assign dx    = tx_busy & tx_sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      hold      <= '0;
      tx_sh     <= '0;
      tx_cnt    <= IDLE;
      enc_start <= 1'b0;
    end else begin
      bclk_q    <= bclk;
      enc_start <= bclk_rise & fsx;
      if (tx_load) hold <= tx_word;
      if (bclk_rise) begin
        if (fsx) begin
          tx_sh  <= hold;
          tx_cnt <= '0;
        end else if (tx_busy) begin
          tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
          tx_cnt <= tx_cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh        <= '0;
      rx_cnt       <= IDLE;
      rx_word      <= '0;
      decode_start <= 1'b0;
    end else begin
      decode_start <= 1'b0;
      if (bclk_rise && fsr) begin
        rx_cnt <= '0;
      end else if (bclk_fall && rx_cnt != IDLE) begin
        rx_sh  <= {rx_sh[WORD_W-2:0], dr};
        rx_cnt <= rx_cnt + CW'(1);
        if (rx_cnt == LAST) begin
          rx_word      <= {rx_sh[WORD_W-2:0], dr};
          decode_start <= 1'b1;
        end
      end
    end
  end

  p_dx_moves_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bclk_rise) |-> $stable(dx));
  p_en_moves_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dx_en) |-> $past(bclk_rise));
  p_enc_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enc_start |=> !enc_start);
  p_dec_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    decode_start |-> $past(bclk_fall));
  p_dec_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decode_start |=> !decode_start);
  p_word_with_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> decode_start);
endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int PERIODS = 12;
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{16'hA5A5, 16'h0101, 16'h8080, 16'hFFFF,
                                         16'h0000, 16'h3C3C, 16'h5A5A, 16'hE7E7};

  logic clk = 0, rst_n = 0, bclk = 0, fsx = 0, fsr = 0, dr = 0, tx_load = 0;
  logic [W-1:0] tx_word = '0;
  logic enc_start, dx, dx_en, decode_start;
  logic [W-1:0] rx_word;

  int n_cmp = 0, n_bad = 0, dec_n = 0, enc_n = 0, cyc = 0;
  logic [W-1:0] last_word = '0, hold_exp = '0;

  pcm_slot_port #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsx(fsx), .fsr(fsr), .dr(dr),
    .tx_load(tx_load), .tx_word(tx_word), .enc_start(enc_start), .dx(dx),
    .dx_en(dx_en), .decode_start(decode_start), .rx_word(rx_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (decode_start) begin dec_n++; last_word = rx_word; end
    if (enc_start) enc_n++;
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp<=150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_period(input logic sx, input logic sr, input logic b,
                            output logic d, output logic e);
    @(negedge clk); bclk = 1; fsx = sx; fsr = sr; dr = ~b;
    @(negedge clk); @(negedge clk); dr = b;
    @(negedge clk); @(negedge clk); d = dx; e = dx_en;
    bclk = 0; fsx = 0; fsr = 0;
    @(negedge clk); @(negedge clk); @(negedge clk);
  endtask

  task automatic pulse_load(input logic [W-1:0] v);
    @(negedge clk); tx_load = 1; tx_word = v;
    @(negedge clk); tx_load = 0;
    hold_exp = v;
  endtask

  task automatic frame(input int fx0, input int fx1, input int fr0, input int fr1,
                       input logic [W-1:0] rxb, input int ld_at, input bit loop,
                       input logic [W-1:0] ldb, input int exp_dec,
                       input logic [W-1:0] exp_word);
    int d0 = dec_n, e0 = enc_n, nfsx = 0, s = -100, rs = -100;
    logic [W-1:0] cur = '0;
    for (int p = 0; p < PERIODS; p++) begin
      logic sx, sr, b, d, e;
      int k, idx;
      bit on;
      sx = (p == fx0) || (p == fx1);
      sr = (p == fr0) || (p == fr1);
      if (sr) rs = p;
      idx = p - rs;
      b = (idx >= 0 && idx < W) ? rxb[W-1-idx] : 1'($urandom);
      if (sx) begin s = p; cur = hold_exp; nfsx++; end
      run_period(sx, sr, b, d, e);
      k = p - s;
      on = (k >= 0 && k < W);
      chk("R4 dx_en window", e, on);
      if (on) chk("R3/R2 dx bit MSB first", d, cur[W-1-k]);
      else    chk("R4 dx low when disabled", d, 1'b0);
      if (p == ld_at) pulse_load(loop ? last_word : ldb);
    end
    chk("R7 enc_start pulses", enc_n - e0, nfsx);
    chk("R9 decode_start count", dec_n - d0, exp_dec);
    if (exp_dec > 0) chk("R8 captured word", last_word, exp_word);
    chk("R9 rx_word held", rx_word, last_word);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dx_en reset", dx_en, 1'b0);
    chk("R1 dx reset", dx, 1'b0);
    chk("R1 decode_start reset", decode_start, 1'b0);
    chk("R1 enc_start reset", enc_start, 1'b0);
    chk("R1 rx_word reset", rx_word, '0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Vector walk: loopback of each received word; the first slot sends the reset hold (R1).
    for (int i = 0; i < NVEC; i++)
      frame(0, -1, 0, -1, VEC[i][15:8], 9, 1'b1, '0, 1, VEC[i][7:0]);

    // R5: no load, same word repeated
    frame(0, -1, -1, -1, '0, -1, 1'b0, '0, 0, '0);
    frame(0, -1, -1, -1, '0, -1, 1'b0, '0, 0, '0);
    // R2: load during a slot only affects the next slot
    frame(0, -1, 0, -1, 8'h96, 2, 1'b0, 8'h3C, 1, 8'h96);
    frame(0, -1, -1, -1, '0, -1, 1'b0, '0, 0, '0);
    // R6: fsx again mid-slot
    frame(0, 3, -1, -1, '0, -1, 1'b0, '0, 0, '0);
    // R10: fsr again mid-capture
    frame(-1, -1, 0, 4, 8'hC3, -1, 1'b0, '0, 1, 8'hC3);
    // R8: distinct pattern with rising-edge decoy on dr
    frame(-1, -1, 0, -1, 8'h6D, -1, 1'b0, '0, 1, 8'h6D);
    finish_run();
  end
endmodule